// File: doc/BRIEF.md
# Four-Tier Priority Round-Robin Transmit Scheduler

This block chooses which of `N_CH` transmit channels is served next. A channel asks for service while its descriptor queue holds work (`q_pend`). It is a candidate only while its enable bit is set and its pause bit is clear. Each channel has a 4-bit priority register, written through a simple configuration port. The register folds onto one of four tiers, and tier 0 is the most urgent.

Arbitration is strict between tiers. Inside a tier, a rotating pointer gives each channel a fair turn, and each tier keeps its own pointer. The winner gets a registered one-hot grant, a valid flag and a binary index. The grant stays fixed until the served channel pulses its `ch_done` bit. The next arbitration takes place one cycle after the release.

Top module: `prio_rr_sched`

## Requirements
- R1: After reset, `grant_vld` is 0, `grant` is all zeros, every rotation pointer points at channel 0, and every priority register is 0, which is tier 0.
- R2: A channel is eligible only when its `q_pend`, `ch_enable` and not-`ch_pause` conditions all hold in the same cycle.
- R3: When eligible channels sit in different tiers, the grant goes to a channel of the lowest-numbered tier.
- R4: Within a tier, the search starts at that tier's pointer and moves upward, wrapping from `N_CH-1` to 0. After a grant, the tier's pointer moves to the channel just above the winner.
- R5: A grant in one tier leaves the pointers of the other tiers unchanged.
- R6: A priority value of 0 to 3 selects that tier. Any value from 4 to 15 selects tier 3, and such a channel shares tier 3's rotation with channels written as 3.
- R7: While `grant_vld` is 1, `grant_idx` stays constant until `ch_done[grant_idx]` is 1 at a clock edge. Done bits of other channels, and changes to pending, enable or pause, have no effect on the held grant.
- R8: The edge that samples the granted channel's done bit clears `grant_vld`. The next grant can appear at the following edge at the earliest.
- R9: With no eligible channel, `grant_vld` stays 0 and `grant` stays zero.
- R10: While `grant_vld` is 1, `grant` has exactly one bit set, at position `grant_idx`.
- R11: A clock edge with `cfg_we` high loads `cfg_prio` into the priority register of channel `cfg_ch`. The new value is used from the next arbitration on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Priority register write strobe |
| cfg_ch | input | IDX_W (3) | Channel whose priority is written |
| cfg_prio | input | PRIO_W (4) | Priority value to write |
| q_pend | input | N_CH (8) | Per-channel queue-not-empty indication |
| ch_enable | input | N_CH (8) | Per-channel enable |
| ch_pause | input | N_CH (8) | Per-channel pause |
| ch_done | input | N_CH (8) | Per-channel packet-finished pulse |
| grant | output | N_CH (8) | One-hot grant |
| grant_vld | output | 1 | A grant is active |
| grant_idx | output | IDX_W (3) | Index of the granted channel |

## Verification
The hardest case to reach from the ports is a tier pointer that another tier has disturbed. A per-tier pointer and a single shared pointer give the same winner unless a grant in one tier happens between two grants in another. To expose the difference, the stimulus first places a grant in tier 0. It then serves a tier-1 channel whose index lies above every tier-0 candidate. The next tier-0 request then picks a channel that a shared pointer would skip. The held-grant case is driven on purpose while the inputs are being disturbed: foreign done bits, a new pending pattern and a pause on the owner are all applied during the hold.

// File: rtl/prio_rr_sched.sv
module prio_rr_sched #(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 4,
  parameter int N_LVL  = 4,
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_ch,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [N_CH-1:0]   q_pend,
  input  logic [N_CH-1:0]   ch_enable,
  input  logic [N_CH-1:0]   ch_pause,
  input  logic [N_CH-1:0]   ch_done,
  output logic [N_CH-1:0]   grant,
  output logic              grant_vld,
  output logic [IDX_W-1:0]  grant_idx
);

  logic [PRIO_W-1:0] prio_q [N_CH];
  logic [LVL_W-1:0]  lvl    [N_CH];
  logic [IDX_W-1:0]  ptr_q  [N_LVL];
  logic [N_LVL-1:0]  hit;
  logic [IDX_W-1:0]  pick   [N_LVL];
  logic [N_CH-1:0]   elig;
  logic              any_win;
  logic [LVL_W-1:0]  win_lvl;
  logic [IDX_W-1:0]  win_idx;
  logic [IDX_W-1:0]  win_nxt;
  logic              gv_q;
  logic [IDX_W-1:0]  gi_q;

  assign elig = q_pend & ch_enable & ~ch_pause;

  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      if (prio_q[c] >= PRIO_W'(N_LVL - 1)) lvl[c] = LVL_W'(N_LVL - 1);
      else                                 lvl[c] = LVL_W'(prio_q[c]);
    end
  end

  always_comb begin
    for (int l = 0; l < N_LVL; l++) begin
      hit[l]  = 1'b0;
      pick[l] = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
        int c;
        c = (int'(ptr_q[l]) + i) % N_CH;
        if (elig[c] && lvl[c] == LVL_W'(l)) begin
          hit[l]  = 1'b1;
          pick[l] = IDX_W'(c);
        end
      end
    end
  end

  always_comb begin
    any_win = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    for (int l = N_LVL - 1; l >= 0; l--) begin
      if (hit[l]) begin
        any_win = 1'b1;
        win_lvl = LVL_W'(l);
        win_idx = pick[l];
      end
    end
  end

  assign win_nxt = (win_idx == IDX_W'(N_CH - 1)) ? '0 : win_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q <= 1'b0;
      gi_q <= '0;
      for (int l = 0; l < N_LVL; l++) ptr_q[l] <= '0;
      for (int c = 0; c < N_CH; c++) prio_q[c] <= '0;
    end else begin
      if (cfg_we && int'(cfg_ch) < N_CH) prio_q[cfg_ch] <= cfg_prio;
      if (gv_q) begin
        if (ch_done[gi_q]) gv_q <= 1'b0;
      end else if (any_win) begin
        gv_q           <= 1'b1;
        gi_q           <= win_idx;
        ptr_q[win_lvl] <= win_nxt;
      end
    end
  end

  assign grant_vld = gv_q;
  assign grant_idx = gi_q;
  assign grant     = gv_q ? (N_CH'(1) << gi_q) : '0;

endmodule

// File: rtl/prio_rr_sched_chk.sv
module prio_rr_sched_chk #(
  parameter int N_CH  = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CH-1:0]  q_pend,
  input logic [N_CH-1:0]  ch_enable,
  input logic [N_CH-1:0]  ch_pause,
  input logic [N_CH-1:0]  ch_done,
  input logic [N_CH-1:0]  grant,
  input logic             grant_vld,
  input logic [IDX_W-1:0] grant_idx
);

  logic [N_CH-1:0] elig_now;
  logic [N_CH-1:0] elig_d;

  assign elig_now = q_pend & ch_enable & ~ch_pause;

  always_ff @(posedge clk) elig_d <= elig_now;

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && !ch_done[grant_idx] |=> grant_vld && $stable(grant_idx)); // R7

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && ch_done[grant_idx] |=> !grant_vld); // R8

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> elig_d[grant_idx]); // R2

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld && elig_now == '0 |=> !grant_vld); // R9

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> $countones(grant) == 1 && grant[grant_idx]); // R10

endmodule

bind prio_rr_sched prio_rr_sched_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .q_pend(q_pend), .ch_enable(ch_enable),
  .ch_pause(ch_pause), .ch_done(ch_done), .grant(grant),
  .grant_vld(grant_vld), .grant_idx(grant_idx)
);

// File: tb/test_prio_rr_sched.sv
module test_prio_rr_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_ch = '0;
  logic [3:0] cfg_prio = '0;
  logic [7:0] q_pend = '0, ch_enable = '0, ch_pause = '0, ch_done = '0;
  logic [7:0] grant;
  logic       grant_vld;
  logic [2:0] grant_idx;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  prio_rr_sched i_prio_rr_sched (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_prio(cfg_prio),
    .q_pend(q_pend), .ch_enable(ch_enable), .ch_pause(ch_pause), .ch_done(ch_done),
    .grant(grant), .grant_vld(grant_vld), .grant_idx(grant_idx)
  );

  // {pend, enable, pause, expected valid, expected index}, all channels in tier 0
  localparam logic [27:0] VEC [12] = '{
    {8'h00, 8'hFF, 8'h00, 1'b0, 3'd0},
    {8'hFF, 8'hFF, 8'h00, 1'b1, 3'd0},
    {8'hFF, 8'hFF, 8'h00, 1'b1, 3'd1},
    {8'h01, 8'hFF, 8'h00, 1'b1, 3'd0},
    {8'h81, 8'hFF, 8'h00, 1'b1, 3'd7},
    {8'h81, 8'hFF, 8'h00, 1'b1, 3'd0},
    {8'hFF, 8'hF0, 8'h00, 1'b1, 3'd4},
    {8'hFF, 8'hFF, 8'h60, 1'b1, 3'd7},
    {8'h0C, 8'h04, 8'h00, 1'b1, 3'd2},
    {8'hFF, 8'h00, 8'h00, 1'b0, 3'd0},
    {8'h00, 8'hFF, 8'h00, 1'b0, 3'd0},
    {8'h10, 8'hFF, 8'h10, 1'b0, 3'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] ch, input logic [3:0] p);
    cfg_we = 1'b1; cfg_ch = ch; cfg_prio = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input logic [7:0] p, input logic [7:0] e, input logic [7:0] s,
                      input logic xv, input logic [2:0] xi, input string tag);
    q_pend = p; ch_enable = e; ch_pause = s;
    @(negedge clk);
    check(grant_vld == xv, {tag, " valid"}, grant_vld, xv);
    if (xv) begin
      check(grant_idx == xi, {tag, " index"}, grant_idx, xi);
      check(grant == (8'd1 << xi), "R10 one-hot", grant, 8'd1 << xi);
    end else begin
      check(grant == 8'd0, {tag, " grant zero"}, grant, 0);
    end
    if (grant_vld) begin
      ch_done = grant;
      @(negedge clk);
      ch_done = '0;
      check(!grant_vld, "R8 release", grant_vld, 0);
    end
    q_pend = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    check(!grant_vld, "R1 reset valid", grant_vld, 0);
    check(grant == 8'd0, "R1 reset grant", grant, 0);

    for (int k = 0; k < 12; k++) begin
      step(VEC[k][27:20], VEC[k][19:12], VEC[k][11:4], VEC[k][3], VEC[k][2:0],
           $sformatf("R2/R4/R9 vec%0d", k));
    end

    // R3 and R11: tiers from written priorities
    cfg(3'd3, 4'd1);
    cfg(3'd5, 4'd2);
    step(8'h28, 8'hFF, 8'h00, 1'b1, 3'd3, "R3 tier1 over tier2");
    step(8'h2C, 8'hFF, 8'h00, 1'b1, 3'd2, "R3 tier0 first");

    // R6: out-of-range priority folds to tier 3
    cfg(3'd6, 4'd15);
    step(8'h60, 8'hFF, 8'h00, 1'b1, 3'd5, "R6 tier2 over 15");
    cfg(3'd7, 4'd3);
    step(8'hC0, 8'hFF, 8'h00, 1'b1, 3'd6, "R6 shared rotation a");
    step(8'hC0, 8'hFF, 8'h00, 1'b1, 3'd7, "R6 shared rotation b");
    step(8'hC0, 8'hFF, 8'h00, 1'b1, 3'd6, "R4 tier3 wrap");

    // R5: tier pointers independent
    step(8'h07, 8'hFF, 8'h00, 1'b1, 3'd0, "R5 tier0 first");
    cfg(3'd4, 4'd1);
    step(8'h18, 8'hFF, 8'h00, 1'b1, 3'd4, "R5 tier1 grant");
    step(8'h07, 8'hFF, 8'h00, 1'b1, 3'd1, "R5 tier0 untouched");
    step(8'h18, 8'hFF, 8'h00, 1'b1, 3'd3, "R5 tier1 wrap");

    // R7 and R8: hold under disturbance, then one idle cycle, then re-arbitration
    q_pend = 8'h01; ch_enable = 8'hFF; ch_pause = '0;
    @(negedge clk);
    check(grant_vld && grant_idx == 3'd0, "R7 initial grant", grant_idx, 0);
    q_pend = 8'hFF; ch_pause = 8'h01; ch_done = 8'hFE;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(grant_vld && grant_idx == 3'd0, "R7 held", grant_idx, 0);
    end
    ch_done = 8'h01;
    @(negedge clk);
    ch_done = '0;
    check(!grant_vld, "R8 gap cycle", grant_vld, 0);
    @(negedge clk);
    check(grant_vld && grant_idx == 3'd1, "R8 next arbitration", grant_idx, 1);
    ch_done = grant;
    q_pend = '0; ch_pause = '0;
    @(negedge clk);
    ch_done = '0;

    // R11 then R1: priorities return to tier 0 on reset
    cfg(3'd1, 4'd3);
    step(8'h06, 8'hFF, 8'h00, 1'b1, 3'd2, "R11 ch1 demoted");
    do_reset();
    check(!grant_vld, "R1 second reset valid", grant_vld, 0);
    step(8'h06, 8'hFF, 8'h00, 1'b1, 3'd1, "R1 priorities cleared");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule